// File: doc/BRIEF.md
# Sync-Restartable Clock Post-Divider

This block divides a fast reference clock down to a programmable output clock. Each reference tick is one half of a VCO period, so every timing decision lands on a half-VCO-period grid. The divide ratio N is counted in ticks. Each output period is a high phase of ceil(N/2) ticks followed by a low phase of floor(N/2) ticks. The reference clock is never gated. Stopping and restarting are done only by freezing and reloading the internal period counter.

An external SYNC pin lets a system realign the output phase. A polarity input picks which SYNC direction is the "active" one. The opposite, "inactive" edge starts a clean stop: a high phase already under way runs to its full length, then the output is parked low and a stopped flag is raised. The next active edge restarts the counter from the ratio present at that moment. The first output rising edge then follows the SYNC edge after a fixed number of ticks, and it begins a full-length high phase. SYNC passes through a two-stage synchronizer before any edge is detected.

Top module: `clk_sync_div`

## Requirements
- R1: While `arstN` is low, `divClkOut` and `stopped` are both 0. On the first `refClk` rising edge after release, `divClkOut` goes high and starts a high phase of ceil(N/2) ticks.
- R2: While running, the output repeats a high phase of ceil(N/2) ticks and a low phase of floor(N/2) ticks. N is the value of `divRatio`; values 0 and 1 act as 2.
- R3: A change of `divRatio` does not alter the period in progress. It is taken up only when the next period begins, at the output rising edge.
- R4: With `syncActiveHigh`=1, a falling SYNC edge stops the output and a rising edge restarts it. With `syncActiveHigh`=0, the two directions swap roles.
- R5: After an inactive SYNC edge, any high phase in progress completes its full ceil(N/2) ticks. The output is then held low and `stopped` becomes 1. The output never drops from high while `stopped` is 1, and no high pulse is ever shortened.
- R6: While `stopped` is 1, `divClkOut` stays 0. Both hold until an active SYNC edge arrives.
- R7: SYNC may change between two `refClk` rising edges. If it changes to the active direction while stopped, `divClkOut` rises and `stopped` falls on the third rising edge after that change. The first high phase is a full ceil(N/2) ticks of the ratio present at restart.
- R8: An active edge may arrive during the stop sequence while the output is still high. In that case the high phase completes, the output is low for exactly one tick, and a normal full period then starts. `stopped` stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; one tick is half a VCO period |
| arstN | input | 1 | Asynchronous active-low reset |
| divRatio | input | 8 | Divide ratio N in ticks (values below 2 act as 2) |
| syncActiveHigh | input | 1 | 1: rising SYNC edge restarts; 0: falling SYNC edge restarts |
| syncIn | input | 1 | Asynchronous SYNC pin |
| divClkOut | output | 1 | Divided output clock, driven from a register |
| stopped | output | 1 | 1 while the output is parked low after a stop |

## Verification
The properties assume that `syncActiveHigh` is static outside reset. They also assume that `syncIn` rests at its post-restart level (equal to `syncActiveHigh`) while reset is applied, so the synchronizer does not report a false inactive edge when reset releases. The bench changes polarity only under reset and presets `syncIn` to that idle level first. It moves SYNC only at falling `refClk` edges, so the three-tick restart latency is exact. It sweeps ratios and the point within the period at which the stop is requested, for both polarities.

// File: rtl/clk_sync_div_pkg.sv
`timescale 1ns/1ps
package clk_sync_div_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_DRAINING = 2'd1,
    ST_HALTED   = 2'd2
  } runState_t;

  // Strobes from the control side to the counter datapath.
  typedef struct packed {
    logic advance;  // step the period counter by one tick
    logic restart;  // reload counter, begin a fresh high phase
  } divStrobe_t;

endpackage

// File: rtl/sync_stop_ctrl.sv
`timescale 1ns/1ps
module sync_stop_ctrl
  import clk_sync_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       refClk,
  input  logic       arstN,
  input  logic       syncIn,
  input  logic       syncActiveHigh,
  input  logic       clkOutNow,
  output divStrobe_t strobe,
  output logic       stopped
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncShift;
  logic syncPrev;
  logic syncNow;

  generate
    if (SYNC_STAGES == 1) begin : g_oneStage
      always_ff @(posedge refClk or negedge arstN) begin
        if (!arstN) syncShift <= '0;
        else        syncShift <= syncIn;
      end
    end else begin : g_chain
      always_ff @(posedge refClk or negedge arstN) begin
        if (!arstN) syncShift <= '0;
        else        syncShift <= {syncShift[SYNC_STAGES-2:0], syncIn};
      end
    end
  endgenerate

  assign syncNow = syncShift[LAST];

  always_ff @(posedge refClk or negedge arstN) begin
    if (!arstN) syncPrev <= 1'b0;
    else        syncPrev <= syncNow;
  end

  logic riseSeen, fallSeen, goEdge, haltEdge;
  assign riseSeen = syncNow & ~syncPrev;
  assign fallSeen = ~syncNow & syncPrev;
  assign goEdge   = syncActiveHigh ? riseSeen : fallSeen;
  assign haltEdge = syncActiveHigh ? fallSeen : riseSeen;

  runState_t state, stateNext;
  logic pendGo, pendGoNext;

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    pendGoNext = pendGo;
    unique case (state)
      ST_RUN: begin
        strobe.advance = 1'b1;
        pendGoNext     = 1'b0;
        if (haltEdge) stateNext = ST_DRAINING;
      end
      ST_DRAINING: begin
        if (clkOutNow) begin
          strobe.advance = 1'b1;
          if (goEdge)   pendGoNext = 1'b1;
          if (haltEdge) pendGoNext = 1'b0;
        end else if (pendGo || goEdge) begin
          strobe.restart = 1'b1;
          pendGoNext     = 1'b0;
          stateNext      = ST_RUN;
        end else begin
          stateNext = ST_HALTED;
        end
      end
      ST_HALTED: begin
        if (goEdge) begin
          strobe.restart = 1'b1;
          stateNext      = ST_RUN;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge refClk or negedge arstN) begin
    if (!arstN) begin
      state  <= ST_RUN;
      pendGo <= 1'b0;
    end else begin
      state  <= stateNext;
      pendGo <= pendGoNext;
    end
  end

  assign stopped = (state == ST_HALTED);

endmodule

// File: rtl/div_counter_path.sv
`timescale 1ns/1ps
module div_counter_path
  import clk_sync_div_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               refClk,
  input  logic               arstN,
  input  logic [RATIO_W-1:0] divRatio,
  input  divStrobe_t         strobe,
  output logic               clkOut
);

  localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(2);
  localparam logic [RATIO_W-1:0] ONE       = RATIO_W'(1);

  function automatic logic [RATIO_W-1:0] ceilHalf(input logic [RATIO_W-1:0] n);
    return (n >> 1) + {{(RATIO_W-1){1'b0}}, n[0]};
  endfunction

  logic [RATIO_W-1:0] pos, posNext;
  logic [RATIO_W-1:0] nCur, nNext;
  logic [RATIO_W-1:0] ratioEff;
  logic               outNext, wrap;

  assign ratioEff = (divRatio < MIN_RATIO) ? MIN_RATIO : divRatio;
  assign wrap     = (pos >= nCur - ONE);

  always_comb begin
    posNext = pos;
    nNext   = nCur;
    outNext = clkOut;
    if (strobe.restart) begin
      posNext = '0;
      nNext   = ratioEff;
      outNext = 1'b1;
    end else if (strobe.advance) begin
      posNext = wrap ? '0 : pos + ONE;
      nNext   = wrap ? ratioEff : nCur;
      outNext = (posNext < ceilHalf(nNext));
    end
  end

  // Reset parks the counter on its last tick so the first edge starts a period.
  always_ff @(posedge refClk or negedge arstN) begin
    if (!arstN) begin
      pos    <= ONE;
      nCur   <= MIN_RATIO;
      clkOut <= 1'b0;
    end else begin
      pos    <= posNext;
      nCur   <= nNext;
      clkOut <= outNext;
    end
  end

endmodule

// File: rtl/clk_sync_div.sv
`timescale 1ns/1ps
module clk_sync_div
  import clk_sync_div_pkg::*;
#(
  parameter int RATIO_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               refClk,
  input  logic               arstN,
  input  logic [RATIO_W-1:0] divRatio,
  input  logic               syncActiveHigh,
  input  logic               syncIn,
  output logic               divClkOut,
  output logic               stopped
);

  divStrobe_t strobe;

  sync_stop_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .refClk         (refClk),
    .arstN          (arstN),
    .syncIn         (syncIn),
    .syncActiveHigh (syncActiveHigh),
    .clkOutNow      (divClkOut),
    .strobe         (strobe),
    .stopped        (stopped)
  );

  div_counter_path #(.RATIO_W(RATIO_W)) u_path (
    .refClk   (refClk),
    .arstN    (arstN),
    .divRatio (divRatio),
    .strobe   (strobe),
    .clkOut   (divClkOut)
  );

endmodule

// File: rtl/clk_sync_div_checker.sv
`timescale 1ns/1ps
module clk_sync_div_checker (
  input logic refClk,
  input logic arstN,
  input logic divClkOut,
  input logic stopped
);

  assert_halted_low_R6: assert property (@(posedge refClk) disable iff (!arstN)
    stopped |-> !divClkOut);

  assert_park_after_low_R5: assert property (@(posedge refClk) disable iff (!arstN)
    $rose(stopped) |-> !$past(divClkOut));

  assert_no_cut_high_R5: assert property (@(posedge refClk) disable iff (!arstN)
    $fell(divClkOut) |-> !stopped);

  assert_restart_high_R7: assert property (@(posedge refClk) disable iff (!arstN)
    $fell(stopped) |-> divClkOut);

endmodule

bind clk_sync_div clk_sync_div_checker u_chk (
  .refClk    (refClk),
  .arstN     (arstN),
  .divClkOut (divClkOut),
  .stopped   (stopped)
);

// File: tb/clk_sync_div_bench.sv
`timescale 1ns/1ps
module clk_sync_div_bench;

  logic       refClk = 1'b0;
  logic       arstN;
  logic [7:0] divRatio;
  logic       syncActiveHigh;
  logic       syncIn;
  logic       divClkOut;
  logic       stopped;

  always #5 refClk = ~refClk;

  clk_sync_div u_clk_sync_div (
    .refClk         (refClk),
    .arstN          (arstN),
    .divRatio       (divRatio),
    .syncActiveHigh (syncActiveHigh),
    .syncIn         (syncIn),
    .divClkOut      (divClkOut),
    .stopped        (stopped)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // High-run monitor: every complete high pulse must be ceil(N/2) long (R5).
  bit monOn = 1'b0;
  int expHi = 1;
  bit runOk = 1'b0;
  bit prevOut = 1'b0;
  int hiRun = 0;
  always @(negedge refClk) begin
    if (!monOn) runOk = 1'b0;
    else if (divClkOut && !prevOut) begin runOk = 1'b1; hiRun = 1; end
    else if (divClkOut) hiRun++;
    else if (prevOut && runOk) check("R5", "high pulse length", hiRun, expHi);
    prevOut = divClkOut;
  end

  task automatic tick();
    @(posedge refClk);
    @(negedge refClk);
  endtask

  function automatic int effN(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic doReset(input bit pol, input int n);
    monOn = 1'b0;
    @(negedge refClk);
    arstN = 1'b0;
    syncActiveHigh = pol;
    syncIn = pol;
    divRatio = 8'(n);
    repeat (3) @(negedge refClk);
    check("R1", "divClkOut in reset", int'(divClkOut), 0);
    check("R1", "stopped in reset", int'(stopped), 0);
    arstN = 1'b1;
    tick();
    check("R1", "first edge after reset high", int'(divClkOut), 1);
  endtask

  // Starts on the first high sample of a period, ends on the next one.
  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (divClkOut && hi < 600) begin hi++; tick(); end
    while (!divClkOut && lo < 600) begin lo++; tick(); end
  endtask

  bit finished = 1'b0;

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    int hi, lo;
    arstN = 1'b0;
    divRatio = 8'd4;
    syncActiveHigh = 1'b1;
    syncIn = 1'b1;

    // R1, R2: free-running periods for a sweep of ratios, both polarities.
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 9; k++) begin
        int n, ne;
        case (k)
          0: n = 0; 1: n = 1; 2: n = 2; 3: n = 3; 4: n = 4;
          5: n = 5; 6: n = 8; 7: n = 9; default: n = 17;
        endcase
        ne = effN(n);
        doReset(p[0], n);
        measure(hi, lo);
        check("R1", "first high phase", hi, (ne + 1) / 2);
        check("R2", "first low phase", lo, ne / 2);
        for (int r = 0; r < 2; r++) begin
          measure(hi, lo);
          check("R2", "high phase", hi, (ne + 1) / 2);
          check("R2", "low phase", lo, ne / 2);
        end
      end
    end

    // R3: ratio change mid-period applies only from the next period.
    doReset(1'b1, 6);
    measure(hi, lo);
    divRatio = 8'd11;
    measure(hi, lo);
    check("R3", "old high after change", hi, 3);
    check("R3", "old low after change", lo, 3);
    measure(hi, lo);
    check("R3", "new high", hi, 6);
    check("R3", "new low", lo, 5);

    // R4..R7: stop at every offset in the period, then aligned restart.
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 4; k++) begin
        int n;
        case (k) 0: n = 2; 1: n = 3; 2: n = 5; default: n = 8; endcase
        for (int off = 0; off < n; off++) begin
          int w;
          doReset(p[0], n);
          expHi = (n + 1) / 2;
          monOn = 1'b1;
          repeat (off) tick();
          syncIn = ~p[0];
          w = 0;
          while (!stopped && w < n + 8) begin tick(); w++; end
          check("R4", "stop on inactive edge", int'(stopped), 1);
          check("R5", "parked low", int'(divClkOut), 0);
          for (int h = 0; h < 4; h++) begin
            tick();
            check("R6", "held low while stopped", int'(divClkOut), 0);
            check("R6", "flag held", int'(stopped), 1);
          end
          syncIn = p[0];
          tick();
          tick();
          check("R7", "still low after two edges", int'(divClkOut), 0);
          check("R7", "still stopped after two edges", int'(stopped), 1);
          tick();
          check("R7", "rises on third edge", int'(divClkOut), 1);
          check("R7", "flag clears on third edge", int'(stopped), 0);
          measure(hi, lo);
          check("R7", "full first high after restart", hi, (n + 1) / 2);
          check("R2", "low after restart", lo, n / 2);
        end
      end
    end

    // R8: active edge while still draining a high phase (N=9, high 5).
    doReset(1'b1, 9);
    expHi = 5;
    monOn = 1'b1;
    syncIn = 1'b0;
    tick();
    syncIn = 1'b1;
    for (int i = 2; i <= 11; i++) begin
      int e;
      tick();
      e = (i <= 4 || (i >= 6 && i <= 10)) ? 1 : 0;
      check("R8", $sformatf("output at edge %0d", i), int'(divClkOut), e);
      check("R8", "flag stays low", int'(stopped), 0);
    end
    monOn = 1'b0;

    finishRun();
  end

endmodule